// File: doc/BRIEF.md
# Fast Interrupt Fetch Sequencer

This block sits between a processor's program counter and its instruction fetch port. It tracks the main program counter. When an interrupt request is accepted, it sends fetching to a two-word vector slot through a separate address path, so the main program counter keeps its value. After the slot's two words have been decoded, fetching resumes at the main program counter with no state saved.

A subroutine call decoded inside the slot turns the event into a long interrupt. The return address and the status word are pushed onto an internal 15-entry stack, and fetching jumps to the call target. The long interrupt ends only when a return-from-interrupt is decoded. That return pops the program counter and supplies the saved status word.

Acceptance is paced by decoded instructions, not clock cycles. A request waits in a pending latch until enough main-stream decodes have passed since reset or since the last slot. Software-interrupt, stop and wait instructions are illegal inside the slot and raise a flag.

Top module: `fast_irq_seq`

## Requirements
- R1: Reset sets the fetch address to `RST_ADDR` (default 0x0000). It clears the pending request, the spacing count, the stack pointer and all flags. A request latched before reset is never serviced.
- R2: A main-stream decode advances the program counter by 1, or by 2 when `dec_two` is high. A decoded jump or call loads `dec_target` instead.
- R3: On the decode that accepts a request, the next fetch address becomes the captured vector. The slot then fetches exactly two words: vector+0 and vector+1, or one two-word instruction. After that, fetching returns to the unchanged main program counter.
- R4: A fast slot that contains no call produces no stack push and no stack pop. A return-from-interrupt inside the slot does not pop.
- R5: A call decoded in the slot pushes the unchanged main program counter and `sr_in`, raises `stk_push` for one cycle, and moves fetching to `dec_target`.
- R6: A return-from-interrupt outside the slot with a non-empty stack pops the top entry. It raises `stk_pop` for one cycle, moves fetching to the popped address, and drives the popped status onto `sr_restore`. In a long interrupt it also ends the long mode.
- R7: `illegal` pulses for one cycle after a software-interrupt, stop or wait is decoded in the slot. The same instructions decoded outside the slot leave it low.
- R8: A request can be accepted only on a main-stream decode that is at least the `GAP`th (default 4) since reset or since the last slot ended. Cycles without `dec_valid` do not count.
- R9: A request that arrives during a slot, or before the spacing is met, stays pending and is accepted on the first legal decode.
- R10: A call decoded with 15 entries on the stack sets the sticky `stk_ovf`, writes nothing and gives no `stk_push` pulse.
- R11: A return decoded outside the slot with an empty stack sets the sticky `stk_unf`, gives no `stk_pop` pulse, and advances the program counter as a plain instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request pulse |
| irq_vec | input | AW | Vector slot address, captured with the request |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_two | input | 1 | The decoded instruction is two words long |
| dec_call | input | 1 | The decoded instruction is a subroutine call |
| dec_jump | input | 1 | The decoded instruction is a jump |
| dec_reti | input | 1 | The decoded instruction is a return from interrupt |
| dec_swint | input | 1 | The decoded instruction is a software interrupt |
| dec_stop | input | 1 | The decoded instruction is a stop |
| dec_wait | input | 1 | The decoded instruction is a wait |
| dec_target | input | AW | Target of a call or jump |
| sr_in | input | SW | Current status word, pushed on a call |
| fetch_addr | output | AW | Address of the next word to fetch |
| main_pc | output | AW | Main program counter |
| stk_push | output | 1 | One-cycle pulse: an entry was pushed |
| stk_pop | output | 1 | One-cycle pulse: an entry was popped |
| sr_restore | output | SW | Status word from the last pop |
| illegal | output | 1 | One-cycle pulse: forbidden instruction in the slot |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |

## Verification
The hardest case to reach is the interaction of the spacing rule with requests that arrive at awkward moments. Examples are a request raised inside a running slot, a request held across stretches of cycles with no decode, and a request latched just before reset. The stimulus is a table of back-to-back decodes that chains three fast slots and one long interrupt, with request pulses placed inside slots and in the first main decode after a slot. Directed runs then insert idle cycles before the fourth decode and assert reset over a pending request. Sixteen nested calls followed by a return walk the stack past its full boundary.

// File: rtl/fast_irq_seq.sv
module fast_irq_seq #(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int DEPTH = 15,
  parameter int GAP = 4,
  parameter logic [AW-1:0] RST_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic [AW-1:0] irq_vec,
  input  logic          dec_valid,
  input  logic          dec_two,
  input  logic          dec_call,
  input  logic          dec_jump,
  input  logic          dec_reti,
  input  logic          dec_swint,
  input  logic          dec_stop,
  input  logic          dec_wait,
  input  logic [AW-1:0] dec_target,
  input  logic [SW-1:0] sr_in,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] main_pc,
  output logic          stk_push,
  output logic          stk_pop,
  output logic [SW-1:0] sr_restore,
  output logic          illegal,
  output logic          stk_ovf,
  output logic          stk_unf
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int GW = $clog2(GAP) + 1;
  localparam logic [GW-1:0] GAP_MAX = GW'(GAP - 1);
  localparam logic [SPW-1:0] SP_FULL = SPW'(DEPTH);

  typedef enum logic [1:0] {M_MAIN, M_FAST, M_LONG} mode_t;

  mode_t           mode_q;
  logic [AW-1:0]   pc_q, vbase_q, pvec_q;
  logic            voff_q, pend_q;
  logic [GW-1:0]   gap_q;
  logic [SPW-1:0]  sp_q;
  logic [AW+SW-1:0] stk_mem [DEPTH];

  wire in_fast = (mode_q == M_FAST);
  wire [AW-1:0] pc_seq = pc_q + (dec_two ? AW'(2) : AW'(1));
  wire [1:0] slot_words = {1'b0, voff_q} + (dec_two ? 2'd2 : 2'd1);
  wire [SPW-1:0] sp_dec = sp_q - SPW'(1);
  wire [AW+SW-1:0] stk_top = stk_mem[sp_dec];
  wire stk_full = (sp_q == SP_FULL);
  wire stk_empty = (sp_q == '0);
  wire do_push = dec_valid && dec_call && !stk_full;
  wire do_pop = dec_valid && dec_reti && !in_fast && !stk_empty;
  wire accept = dec_valid && (mode_q == M_MAIN) && pend_q && (gap_q == GAP_MAX);

  assign fetch_addr = in_fast ? vbase_q + AW'(voff_q) : pc_q;
  assign main_pc = pc_q;

  always_ff @(posedge clk) begin
    if (do_push) stk_mem[sp_q] <= {(in_fast ? pc_q : pc_seq), sr_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_MAIN;
      pc_q       <= RST_ADDR;
      vbase_q    <= '0;
      pvec_q     <= '0;
      voff_q     <= 1'b0;
      pend_q     <= 1'b0;
      gap_q      <= '0;
      sp_q       <= '0;
      stk_push   <= 1'b0;
      stk_pop    <= 1'b0;
      sr_restore <= '0;
      illegal    <= 1'b0;
      stk_ovf    <= 1'b0;
      stk_unf    <= 1'b0;
    end else begin
      stk_push <= do_push;
      stk_pop  <= do_pop;
      illegal  <= dec_valid && in_fast && (dec_swint || dec_stop || dec_wait);
      if (dec_valid && dec_call && stk_full) stk_ovf <= 1'b1;
      if (dec_valid && dec_reti && !in_fast && stk_empty) stk_unf <= 1'b1;
      if (do_push) sp_q <= sp_q + SPW'(1);
      else if (do_pop) sp_q <= sp_dec;
      if (do_pop) sr_restore <= stk_top[SW-1:0];

      if (accept) begin
        pend_q <= irq_req;
        pvec_q <= irq_vec;
      end else if (irq_req && !pend_q) begin
        pend_q <= 1'b1;
        pvec_q <= irq_vec;
      end

      if (dec_valid) begin
        case (mode_q)
          M_FAST: begin
            if (dec_call) begin
              pc_q   <= dec_target;
              mode_q <= M_LONG;
              voff_q <= 1'b0;
            end else if (slot_words[1]) begin
              mode_q <= M_MAIN;
              voff_q <= 1'b0;
            end else begin
              voff_q <= 1'b1;
            end
          end
          default: begin
            if (dec_call || dec_jump) pc_q <= dec_target;
            else if (do_pop) pc_q <= stk_top[AW+SW-1:SW];
            else pc_q <= pc_seq;
            if (mode_q == M_LONG) begin
              if (dec_reti) begin
                mode_q <= M_MAIN;
                gap_q  <= '0;
              end
            end else if (accept) begin
              mode_q  <= M_FAST;
              vbase_q <= pvec_q;
              voff_q  <= 1'b0;
              gap_q   <= '0;
            end else if (gap_q != GAP_MAX) begin
              gap_q <= gap_q + GW'(1);
            end
          end
        endcase
      end
    end
  end

  // R3
  main_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fast && !(dec_valid && dec_call)) |=> $stable(main_pc));

  // R4
  fast_no_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fast && dec_valid && !dec_call) |=> (!stk_push && !stk_pop));

  // R5
  push_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push |-> $past(dec_valid && dec_call));

  // R7
  illegal_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(in_fast && dec_valid));

  // R8
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fast && $past(mode_q) == M_MAIN) |-> ($past(gap_q) == GAP_MAX));

  // R10
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full && dec_valid && dec_call) |=> (stk_ovf && !stk_push));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

  // R11
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf |=> stk_unf);
endmodule

// File: tb/sim_fast_irq_seq.sv
module sim_fast_irq_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 1'b0;
  logic [15:0] irq_vec = 16'h0040;
  logic dec_valid = 1'b0, dec_two = 1'b0, dec_call = 1'b0, dec_jump = 1'b0;
  logic dec_reti = 1'b0, dec_swint = 1'b0, dec_stop = 1'b0, dec_wait = 1'b0;
  logic [15:0] dec_target = '0;
  logic [7:0] sr_in = '0;
  logic [15:0] fetch_addr, main_pc;
  logic stk_push, stk_pop, illegal, stk_ovf, stk_unf;
  logic [7:0] sr_restore;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fast_irq_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .dec_valid(dec_valid), .dec_two(dec_two), .dec_call(dec_call),
    .dec_jump(dec_jump), .dec_reti(dec_reti), .dec_swint(dec_swint),
    .dec_stop(dec_stop), .dec_wait(dec_wait), .dec_target(dec_target),
    .sr_in(sr_in), .fetch_addr(fetch_addr), .main_pc(main_pc),
    .stk_push(stk_push), .stk_pop(stk_pop), .sr_restore(sr_restore),
    .illegal(illegal), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  // ctrl {irq,two,call,jump,reti,swint,stop,wait}, target, exp fetch, exp {push,pop,ill}, exp sr
  localparam int N = 25;
  localparam logic [50:0] VEC [N] = '{
    {8'b1001_0000, 16'h0100, 16'h0100, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0101, 3'b000, 8'h00},
    {8'b0100_0000, 16'h0000, 16'h0103, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0040, 3'b000, 8'h00},
    {8'b1000_0000, 16'h0000, 16'h0041, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0104, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0105, 3'b000, 8'h00},
    {8'b0100_0000, 16'h0000, 16'h0107, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0108, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0040, 3'b000, 8'h00},
    {8'b0100_0000, 16'h0000, 16'h0109, 3'b000, 8'h00},
    {8'b1000_0000, 16'h0000, 16'h010A, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h010B, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h010C, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0040, 3'b000, 8'h00},
    {8'b0010_0000, 16'h0200, 16'h0200, 3'b100, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0201, 3'b000, 8'h00},
    {8'b0000_1000, 16'h0000, 16'h010D, 3'b010, 8'h0F},
    {8'b1000_0000, 16'h0000, 16'h010E, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h010F, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0110, 3'b000, 8'h00},
    {8'b0000_0000, 16'h0000, 16'h0040, 3'b000, 8'h00},
    {8'b0000_0100, 16'h0000, 16'h0041, 3'b001, 8'h00},
    {8'b0000_0010, 16'h0000, 16'h0111, 3'b001, 8'h00},
    {8'b0000_0001, 16'h0000, 16'h0112, 3'b000, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] c, input logic [15:0] t, input logic [7:0] s);
    dec_valid = v;
    {irq_req, dec_two, dec_call, dec_jump, dec_reti, dec_swint, dec_stop, dec_wait} = c;
    dec_target = t;
    sr_in = s;
    @(posedge clk);
    @(negedge clk);
    dec_valid = 1'b0;
    {irq_req, dec_two, dec_call, dec_jump, dec_reti, dec_swint, dec_stop, dec_wait} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 fetch after reset", 32'(fetch_addr), 32'h0000);
    check("R1 flags after reset", {illegal, stk_ovf, stk_unf, stk_push, stk_pop}, 0);

    for (int i = 0; i < N; i++) begin
      step(1'b1, VEC[i][50:43], VEC[i][42:27], 8'(i));
      // R2 R3 R8 R9 fetch sequence
      check($sformatf("R2 R3 R9 fetch row %0d", i), 32'(fetch_addr), 32'(VEC[i][26:11]));
      // R4 R5 push, R6 pop, R7 illegal
      check($sformatf("R4 R5 push row %0d", i), 32'(stk_push), 32'(VEC[i][10]));
      check($sformatf("R6 pop row %0d", i), 32'(stk_pop), 32'(VEC[i][9]));
      check($sformatf("R7 illegal row %0d", i), 32'(illegal), 32'(VEC[i][8]));
      if (VEC[i][9]) check("R6 status restore", 32'(sr_restore), 32'(VEC[i][7:0]));
    end

    // R8 idle cycles do not count toward spacing
    do_reset();
    irq_vec = 16'h0080;
    step(1'b0, 8'b1000_0000, 16'h0, 8'h0);
    repeat (10) @(negedge clk);
    check("R8 no accept without decodes", 32'(fetch_addr), 32'h0000);
    for (int k = 1; k <= 3; k++) begin
      step(1'b1, 8'h00, 16'h0, 8'h0);
      repeat (3) @(negedge clk);
      check("R8 early decode not accepted", 32'(fetch_addr), 32'(k));
    end
    step(1'b1, 8'h00, 16'h0, 8'h0);
    check("R8 fourth decode accepts", 32'(fetch_addr), 32'h0080);
    check("R3 main pc held", 32'(main_pc), 32'h0004);

    // R1 pending request dropped by reset
    step(1'b0, 8'b1000_0000, 16'h0, 8'h0);
    do_reset();
    for (int k = 1; k <= 5; k++) begin
      step(1'b1, 8'h00, 16'h0, 8'h0);
      check("R1 pending cleared by reset", 32'(fetch_addr), 32'(k));
    end

    // R11 pop on empty stack
    do_reset();
    step(1'b1, 8'b0000_1000, 16'h0, 8'h0);
    check("R11 underflow flag", 32'(stk_unf), 32'h1);
    check("R11 no pop pulse", 32'(stk_pop), 32'h0);
    check("R11 pc advances", 32'(fetch_addr), 32'h0001);

    // R10 overflow on sixteenth call
    do_reset();
    for (int k = 0; k < 15; k++) step(1'b1, 8'b0010_0000, 16'h1000 + 16'(k), 8'(k));
    check("R10 no overflow at 15", 32'(stk_ovf), 32'h0);
    step(1'b1, 8'b0010_0000, 16'h100F, 8'hEE);
    check("R10 overflow flag", 32'(stk_ovf), 32'h1);
    check("R10 no push pulse", 32'(stk_push), 32'h0);
    check("R10 call still jumps", 32'(fetch_addr), 32'h100F);
    step(1'b1, 8'b0000_1000, 16'h0, 8'h0);
    check("R10 pop returns last stored", 32'(fetch_addr), 32'h100E);
    check("R10 status of last stored", 32'(sr_restore), 32'h0E);
    check("R10 overflow sticky", 32'(stk_ovf), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule